// File: doc/BRIEF.md
# Multi-Cycle 8-Bit Processor Sequencer

This block is a small processor core that does not overlap instructions. It has a 16-bit byte address bus and an 8-bit data bus. Instruction bytes and data bytes sit in one shared memory and travel over the same two buses. A control state machine takes each instruction through fetch, then decode, then execute. Each phase waits for the previous one to finish. At most one memory access happens per clock. Instructions therefore take different numbers of cycles: operand bytes and stack bytes each cost an extra bus cycle.

Three opcodes are supported:

- load-accumulator-immediate (`0xA9`)
- call-subroutine with a two-byte absolute target (`0x20`)
- return-from-subroutine (`0x60`)

Any other opcode stops the core until reset. The program counter, stack pointer, accumulator, zero flag and negative flag are visible at the ports. A one-cycle `retire` strobe marks the last cycle of each instruction.

Memory reads have a fixed latency of one cycle. In one cycle the core drives the address with `memRd` high. The memory returns the byte on `memRData` during the following cycle, and the core samples it at the end of that cycle.

Top module: `seqcpu`

## Requirements
- R1: While `rstN` is low the core loads PC from `startAddr`, sets SP to 0xFF, and clears the accumulator, Z and N. Once reset has been applied for a cycle, `halted` and `retire` are low and the core presents a fetch: `memRd` high, `memWr` low, `memAddr` equal to `startAddr`.
- R2: `memRd` and `memWr` are never high in the same cycle.
- R3: Read data is taken from `memRData` in the cycle after the one in which `memRd` was high with the address.
- R4: Opcode 0xA9 loads the accumulator with the byte at the opcode address plus 1. It advances PC by 2 and takes 4 cycles: fetch, decode, operand read, execute.
- R5: After a load, Z is 1 exactly when the loaded value is 0, and N equals bit 7 of the loaded value. Nothing else changes either flag.
- R6: Opcode 0x20 reads a target from the next two bytes, low byte first (bytes EE FF give 0xFFEE). It sets PC to that target and takes 7 cycles.
- R7: A 0x20 pushes the address of its own last operand byte (opcode address plus 2). The high byte is written to 0x0100+SP and the low byte to 0x0100+SP-1. SP ends 2 lower. Writes only ever go to page 0x01.
- R8: Opcode 0x60 pulls the low byte from 0x0100+SP+1 and the high byte from 0x0100+SP+2. It sets PC to that address plus 1, raises SP by 2, and takes 6 cycles.
- R9: Any other opcode raises `halted` from the cycle after decode. PC is left at the bad opcode address plus 1. From then until the next reset there are no memory strobes, no retire, and no change to PC, SP, accumulator or flags.
- R10: PC and address arithmetic wrap modulo 2^16, and SP wraps modulo 2^8.
- R11: `retire` is high for exactly the last cycle of each completed instruction. The next cycle is a fetch at the new PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startAddr | input | 16 | Address loaded into PC during reset |
| memAddr | output | 16 | Memory byte address |
| memRd | output | 1 | Read strobe; data is expected on the next cycle |
| memWr | output | 1 | Write strobe for `memWData` at `memAddr` |
| memWData | output | 8 | Write data (stack pushes) |
| memRData | input | 8 | Read data, valid one cycle after `memRd` |
| halted | output | 1 | High once an unsupported opcode has been decoded |
| retire | output | 1 | High in the last cycle of each instruction |
| pcOut | output | 16 | Program counter |
| spOut | output | 8 | Stack pointer |
| accOut | output | 8 | Accumulator |
| zeroFlag | output | 1 | Z status |
| negFlag | output | 1 | N status |

## Verification
Most wrong internal state shows up at the ports within a single instruction:

- A bad PC shows up in the fetch address of the very next cycle after `retire`.
- A wrong cycle count shifts the distance between `retire` pulses.
- A wrong stack byte or SP is hidden until the matching return. At that point it returns PC to the wrong place, which shows up on the next fetch.

For that reason the bench checks the stack contents and SP right after each call instead of waiting for the return. A wrong halt decision shows up two cycles after the fetch of the bad opcode, as strobes continuing or `halted` staying low.

// File: rtl/seqcpu_pkg.sv
package seqcpu_pkg;

  localparam logic [7:0] OP_LDI  = 8'hA9;
  localparam logic [7:0] OP_CALL = 8'h20;
  localparam logic [7:0] OP_RET  = 8'h60;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_LDI_RD,
    ST_LDI_EX,
    ST_CALL_RDLO,
    ST_CALL_LO,
    ST_CALL_HI,
    ST_CALL_PUSHH,
    ST_CALL_PUSHL,
    ST_RET_INC,
    ST_RET_RDLO,
    ST_RET_LO,
    ST_RET_EX,
    ST_HALT
  } seqState_t;

  typedef enum logic {
    ADDR_PC,
    ADDR_STACK
  } addrSel_t;

  // Strobes from sequencer to datapath
  typedef struct packed {
    addrSel_t addrSel;
    logic     memRd;
    logic     memWr;
    logic     wrHigh;
    logic     pcInc;
    logic     pcJump;
    logic     pcReturn;
    logic     accLoad;
    logic     tmpLoLoad;
    logic     tmpHiLoad;
    logic     spInc;
    logic     spDec;
  } ctlStrobe_t;

endpackage

// File: rtl/seqcpu_ctrl.sv
module seqcpu_ctrl
  import seqcpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rdData,
  output ctlStrobe_t        ctl,
  output logic              halted,
  output logic              retire
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= nextState;
  end

  always_comb begin
    ctl         = '0;
    ctl.addrSel = ADDR_PC;
    nextState   = state;
    retire      = 1'b0;
    case (state)
      ST_FETCH: begin
        ctl.memRd = 1'b1;
        nextState = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.pcInc = 1'b1;
        case (rdData)
          DATA_W'(OP_LDI):  nextState = ST_LDI_RD;
          DATA_W'(OP_CALL): nextState = ST_CALL_RDLO;
          DATA_W'(OP_RET):  nextState = ST_RET_INC;
          default:          nextState = ST_HALT;
        endcase
      end
      ST_LDI_RD: begin
        ctl.memRd = 1'b1;
        ctl.pcInc = 1'b1;
        nextState = ST_LDI_EX;
      end
      ST_LDI_EX: begin
        ctl.accLoad = 1'b1;
        retire      = 1'b1;
        nextState   = ST_FETCH;
      end
      ST_CALL_RDLO: begin
        ctl.memRd = 1'b1;
        ctl.pcInc = 1'b1;
        nextState = ST_CALL_LO;
      end
      ST_CALL_LO: begin
        ctl.tmpLoLoad = 1'b1;
        ctl.memRd     = 1'b1;
        nextState     = ST_CALL_HI;
      end
      ST_CALL_HI: begin
        ctl.tmpHiLoad = 1'b1;
        nextState     = ST_CALL_PUSHH;
      end
      ST_CALL_PUSHH: begin
        ctl.addrSel = ADDR_STACK;
        ctl.memWr   = 1'b1;
        ctl.wrHigh  = 1'b1;
        ctl.spDec   = 1'b1;
        nextState   = ST_CALL_PUSHL;
      end
      ST_CALL_PUSHL: begin
        ctl.addrSel = ADDR_STACK;
        ctl.memWr   = 1'b1;
        ctl.spDec   = 1'b1;
        ctl.pcJump  = 1'b1;
        retire      = 1'b1;
        nextState   = ST_FETCH;
      end
      ST_RET_INC: begin
        ctl.spInc = 1'b1;
        nextState = ST_RET_RDLO;
      end
      ST_RET_RDLO: begin
        ctl.addrSel = ADDR_STACK;
        ctl.memRd   = 1'b1;
        ctl.spInc   = 1'b1;
        nextState   = ST_RET_LO;
      end
      ST_RET_LO: begin
        ctl.addrSel   = ADDR_STACK;
        ctl.memRd     = 1'b1;
        ctl.tmpLoLoad = 1'b1;
        nextState     = ST_RET_EX;
      end
      ST_RET_EX: begin
        ctl.pcReturn = 1'b1;
        retire       = 1'b1;
        nextState    = ST_FETCH;
      end
      ST_HALT:  nextState = ST_HALT;
      default:  nextState = ST_HALT;
    endcase
  end

  assign halted = (state == ST_HALT);

  p_one_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.memRd, ctl.memWr}));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!ctl.memRd && !ctl.memWr && !retire));

  p_retire_then_fetch_r11: assert property (@(posedge clk) disable iff (!rstN)
    retire |=> (ctl.memRd && ctl.addrSel == ADDR_PC && !retire));

endmodule

// File: rtl/seqcpu_dpath.sv
module seqcpu_dpath
  import seqcpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0] SP_INIT = 8'hFF,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] startAddr,
  input  ctlStrobe_t        ctl,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] acc,
  output logic              zFlag,
  output logic              nFlag
);

  logic [DATA_W-1:0] tmpLo, tmpHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= startAddr;
    end else if (ctl.pcJump) begin
      pc <= {tmpHi, tmpLo};
    end else if (ctl.pcReturn) begin
      pc <= {rdData, tmpLo} + ADDR_W'(1);
    end else if (ctl.pcInc) begin
      pc <= pc + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          sp <= SP_INIT;
    else if (ctl.spDec) sp <= sp - DATA_W'(1);
    else if (ctl.spInc) sp <= sp + DATA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      zFlag <= 1'b0;
      nFlag <= 1'b0;
    end else if (ctl.accLoad) begin
      acc   <= rdData;
      zFlag <= (rdData == '0);
      nFlag <= rdData[DATA_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmpLo <= '0;
      tmpHi <= '0;
    end else begin
      if (ctl.tmpLoLoad) tmpLo <= rdData;
      if (ctl.tmpHiLoad) tmpHi <= rdData;
    end
  end

  assign memAddr  = (ctl.addrSel == ADDR_STACK) ? {STACK_PAGE, sp} : pc;
  assign memWData = ctl.wrHigh ? pc[ADDR_W-1:DATA_W] : pc[DATA_W-1:0];

  p_zero_matches_r5: assert property (@(posedge clk) disable iff (!rstN)
    zFlag |-> (acc == '0));

  p_neg_matches_r5: assert property (@(posedge clk) disable iff (!rstN)
    nFlag |-> acc[DATA_W-1]);

  p_write_in_stack_page_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWr |-> (memAddr[ADDR_W-1:DATA_W] == STACK_PAGE));

  p_sp_single_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sp) |-> (sp == $past(sp) + DATA_W'(1) || sp == $past(sp) - DATA_W'(1)));

endmodule

// File: rtl/seqcpu.sv
module seqcpu
  import seqcpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0] SP_INIT = 8'hFF,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic              halted,
  output logic              retire,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] accOut,
  output logic              zeroFlag,
  output logic              negFlag
);

  ctlStrobe_t ctl;

  seqcpu_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .rdData (memRData),
    .ctl    (ctl),
    .halted (halted),
    .retire (retire)
  );

  seqcpu_dpath #(
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE),
    .SP_INIT    (SP_INIT)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .startAddr (startAddr),
    .ctl       (ctl),
    .rdData    (memRData),
    .memAddr   (memAddr),
    .memWData  (memWData),
    .pc        (pcOut),
    .sp        (spOut),
    .acc       (accOut),
    .zFlag     (zeroFlag),
    .nFlag     (negFlag)
  );

  assign memRd = ctl.memRd;
  assign memWr = ctl.memWr;

endmodule

// File: tb/seqcpu_tb_top.sv
module seqcpu_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] startAddr = 16'h0000;
  logic [15:0] memAddr;
  logic        memRd, memWr;
  logic [7:0]  memWData;
  logic [7:0]  memRData = 8'h00;
  logic        halted, retire;
  logic [15:0] pcOut;
  logic [7:0]  spOut, accOut;
  logic        zeroFlag, negFlag;

  logic [7:0] mem    [0:65535];
  logic [7:0] refMem [0:65535];

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;
  bit mainDone = 0;

  logic [15:0] refPc;
  logic [7:0]  refSp, refAcc;
  logic        refZ, refN;

  always #4 clk = ~clk;

  seqcpu dut_i (
    .clk(clk), .rstN(rstN), .startAddr(startAddr),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWData(memWData),
    .memRData(memRData), .halted(halted), .retire(retire),
    .pcOut(pcOut), .spOut(spOut), .accOut(accOut),
    .zeroFlag(zeroFlag), .negFlag(negFlag)
  );

  // Memory model: one-cycle read latency
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memWr) mem[memAddr] <= memWData;
    if (memRd) memRData <= mem[memAddr];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic putByte(input logic [15:0] a, input logic [7:0] v);
    mem[a] = v;
    refMem[a] = v;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 65536; i++) begin
      mem[i] = 8'h00;
      refMem[i] = 8'h00;
    end
  endtask

  function automatic bit isKnown(input logic [7:0] op);
    return (op == 8'hA9) || (op == 8'h20) || (op == 8'h60);
  endfunction

  // Reference interpreter, one instruction per call
  task automatic refStep(output int expCyc, output logic [7:0] kind);
    logic [15:0] ret;
    logic [7:0] lo, hi;
    kind = refMem[refPc];
    case (kind)
      8'hA9: begin
        refAcc = refMem[refPc + 16'd1];
        refZ = (refAcc == 8'h00);
        refN = refAcc[7];
        refPc = refPc + 16'd2;
        expCyc = 4;
      end
      8'h20: begin
        lo = refMem[refPc + 16'd1];
        hi = refMem[refPc + 16'd2];
        ret = refPc + 16'd2;
        refMem[{8'h01, refSp}] = ret[15:8];
        refSp = refSp - 8'd1;
        refMem[{8'h01, refSp}] = ret[7:0];
        refSp = refSp - 8'd1;
        refPc = {hi, lo};
        expCyc = 7;
      end
      8'h60: begin
        refSp = refSp + 8'd1;
        lo = refMem[{8'h01, refSp}];
        refSp = refSp + 8'd1;
        hi = refMem[{8'h01, refSp}];
        refPc = {hi, lo} + 16'd1;
        expCyc = 6;
      end
      default: expCyc = -1;
    endcase
  endtask

  // Monitor: cycle counts and architectural state after each retire
  initial begin
    int cnt = 0;
    bit pending = 0;
    int expCyc;
    logic [7:0] kind = 8'h00;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        refPc = startAddr; refSp = 8'hFF; refAcc = 8'h00; refZ = 0; refN = 0;
        cnt = 0; pending = 0;
      end else begin
        chk(!(memRd && memWr), "R2 single access", {memRd, memWr}, 0);
        if (pending) begin
          pending = 0;
          chk(pcOut == refPc, "R11 pc after retire", pcOut, refPc);
          chk(memRd && memAddr == refPc, "R11 fetch at new pc", memAddr, refPc);
          chk(spOut == refSp, "R10 sp", spOut, refSp);
          if (kind == 8'hA9) begin
            chk(accOut == refAcc, "R4 acc (R3 read latency)", accOut, refAcc);
            chk(zeroFlag == refZ && negFlag == refN, "R5 flags",
                {zeroFlag, negFlag}, {refZ, refN});
          end else begin
            chk(accOut == refAcc && zeroFlag == refZ && negFlag == refN,
                "R5 flags unchanged", accOut, refAcc);
          end
          if (kind == 8'h20) begin
            chk(mem[{8'h01, refSp + 8'd1}] == refMem[{8'h01, refSp + 8'd1}],
                "R7 pushed low byte", mem[{8'h01, refSp + 8'd1}], refMem[{8'h01, refSp + 8'd1}]);
            chk(mem[{8'h01, refSp + 8'd2}] == refMem[{8'h01, refSp + 8'd2}],
                "R7 pushed high byte", mem[{8'h01, refSp + 8'd2}], refMem[{8'h01, refSp + 8'd2}]);
            chk(pcOut == refPc, "R6 call target", pcOut, refPc);
          end
          if (kind == 8'h60) chk(pcOut == refPc, "R8 return pc", pcOut, refPc);
        end
        cnt++;
        if (retire) begin
          refStep(expCyc, kind);
          if (kind == 8'hA9)      chk(cnt == expCyc, "R4 cycle count", cnt, expCyc);
          else if (kind == 8'h20) chk(cnt == expCyc, "R6 cycle count", cnt, expCyc);
          else if (kind == 8'h60) chk(cnt == expCyc, "R8 cycle count", cnt, expCyc);
          else                    chk(0, "R11 retire on unsupported opcode", kind, 0);
          cnt = 0;
          pending = 1;
        end
      end
    end
  end

  task automatic runProgram(input logic [15:0] start, input string name);
    logic [15:0] expPc;
    logic [7:0] accHold;
    startAddr = start;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pcOut == start && spOut == 8'hFF, {"R1 pc/sp reset ", name}, pcOut, start);
    chk(accOut == 0 && !zeroFlag && !negFlag, "R1 acc/flags reset", accOut, 0);
    chk(!halted && !retire, "R1 halt/retire low", {halted, retire}, 0);
    chk(memRd && !memWr && memAddr == start, "R1 first fetch", memAddr, start);
    @(posedge clk);
    #2 rstN = 1;
    while (!halted && !finished) @(negedge clk);
    expPc = refPc + 16'd1;
    chk(!isKnown(refMem[refPc]), "R9 halt on unsupported opcode", refMem[refPc], 0);
    chk(pcOut == expPc, "R9 pc after bad opcode", pcOut, expPc);
    accHold = accOut;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(halted && !memRd && !memWr && !retire, "R9 quiet while halted",
          {halted, memRd, memWr, retire}, 4'b1000);
      chk(pcOut == expPc && accOut == accHold && spOut == refSp, "R9 state frozen", pcOut, expPc);
    end
  endtask

  task automatic buildRandom(output logic [15:0] start);
    logic [15:0] a;
    logic [15:0] subBase [0:3];
    logic [7:0] op, v;
    clearMem();
    for (int k = 0; k < 4; k++) subBase[k] = 16'h8000 + 16'(k * 16);
    for (int k = 0; k < 4; k++) begin
      a = subBase[k];
      putByte(a, 8'hA9); putByte(a + 16'd1, 8'($urandom)); a = a + 16'd2;
      if (k < 3) begin
        putByte(a, 8'h20); putByte(a + 16'd1, subBase[k+1][7:0]);
        putByte(a + 16'd2, subBase[k+1][15:8]); a = a + 16'd3;
      end
      putByte(a, 8'h60);
    end
    start = 16'h0200 + 16'($urandom % 32'h4000);
    a = start;
    for (int i = 0; i < 30; i++) begin
      if ($urandom % 3 == 0) begin
        int k = int'($urandom % 4);
        putByte(a, 8'h20); putByte(a + 16'd1, subBase[k][7:0]);
        putByte(a + 16'd2, subBase[k][15:8]); a = a + 16'd3;
      end else begin
        case ($urandom % 5)
          0: v = 8'h00;
          1: v = 8'h80 | 8'($urandom);
          default: v = 8'($urandom);
        endcase
        putByte(a, 8'hA9); putByte(a + 16'd1, v); a = a + 16'd2;
      end
    end
    do op = 8'($urandom); while (isKnown(op));
    putByte(a, op);
  endtask

  initial begin
    logic [15:0] s;
    void'($urandom(32'h5EC0_0042));
    // Directed: call target from bytes EE FF, push at FFFF, return wraps to 0000
    clearMem();
    putByte(16'hFFFB, 8'hA9); putByte(16'hFFFC, 8'h00);
    putByte(16'hFFFD, 8'h20); putByte(16'hFFFE, 8'hEE); putByte(16'hFFFF, 8'hFF);
    putByte(16'hFFEE, 8'hA9); putByte(16'hFFEF, 8'h80); putByte(16'hFFF0, 8'h60);
    putByte(16'h0000, 8'hFF);
    runProgram(16'hFFFB, "wrap");
    chk(pcOut == 16'h0001, "R10 pc wrapped past FFFF", pcOut, 16'h0001);
    chk(mem[16'h01FF] == 8'hFF && mem[16'h01FE] == 8'hFF, "R7 pushed FFFF",
        {mem[16'h01FF], mem[16'h01FE]}, 16'hFFFF);
    chk(accOut == 8'h80 && negFlag && !zeroFlag, "R5 negative load", accOut, 8'h80);
    // Random programs
    for (int r = 0; r < 3; r++) begin
      if (finished) break;
      buildRandom(s);
      runProgram(s, "random");
    end
    mainDone = 1;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    while (!mainDone && cycles < 150000) @(posedge clk);
    if (!mainDone && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule